// File: doc/BRIEF.md
# Pixel-to-Word Packer

This block sits between a camera sensor's pixel-capture logic and a 32-bit receive FIFO. It accepts one unit per valid cycle and assembles the units into 32-bit words. A unit is an 8-bit pixel byte, a 16-bit statistic halfword, or a 24-bit RGB pixel. Each finished word is presented for one cycle with a valid strobe. There is no back-pressure: the consumer must take every word.

Software-style configuration inputs control the assembly. One sets the lane order within a word: either the first unit lands in the low bits, or the first unit lands in the high bits. Another exchanges the two 16-bit halves of every output word. A third places the zero pad byte of an RGB pixel above or below the colour data. A fourth lets an end-of-line marker flush a partly filled word with zero bytes in its empty lanes.

The configuration is expected to stay stable while a word is partly assembled.

Top module: `pix_word_packer`

## Requirements
- R1: Synchronous active-low reset drives out_valid to 0 and out_word to 0, and discards any partly assembled word, so the next word is built only from units accepted after reset.
- R2: With cfg_mode 0 (byte units, taken from in_data[7:0], upper bits ignored) and cfg_msb_first 0, the bytes 0x11, 0x22, 0x33, 0x44 give out_word 0x44332211.
- R3: With cfg_mode 0 and cfg_msb_first 1, the same four bytes give out_word 0x11223344.
- R4: With cfg_mode 1 (halfword units, taken from in_data[15:0]), the halfwords 0xAAAA then 0xBBBB give 0xBBBBAAAA when cfg_msb_first is 0, and 0xAAAABBBB when it is 1.
- R5: When cfg_swap16 is 1, the upper 16 bits and the lower 16 bits of every emitted word are exchanged, in every mode.
- R6: With cfg_mode 2 (RGB, in_data[23:0]), every accepted unit emits one word. That word is {8'h00, data} when cfg_pad_high is 0 and {data, 8'h00} when cfg_pad_high is 1.
- R7: out_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the word's final unit. Idle cycles between units do not disturb the assembly.
- R8: When cfg_zero_pad is 1 and in_eol is high together with in_valid, the partly filled word is emitted at once, with its unfilled lanes zero. The next unit then starts a new word.
- R9: When cfg_zero_pad is 0, in_eol has no effect: a partial word is held until it fills.
- R10: in_eol is ignored in a cycle where in_valid is low.
- R11: cfg_mode 3 behaves exactly as byte mode (cfg_mode 0).
- R12: out_word keeps the last emitted word while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Unit type: 0 byte, 1 halfword, 2 RGB, 3 byte |
| cfg_msb_first | input | 1 | 1 = first unit in the high lane |
| cfg_swap16 | input | 1 | Exchange the 16-bit halves of each output word |
| cfg_pad_high | input | 1 | RGB pad byte at the bottom (1) or the top (0) |
| cfg_zero_pad | input | 1 | Allow end of line to flush a zero-filled partial word |
| in_valid | input | 1 | in_data holds a unit this cycle |
| in_data | input | 24 | Unit data, lower bits used in byte and halfword modes |
| in_eol | input | 1 | Unit presented is the last one of its line |
| out_valid | output | 1 | One-cycle strobe for a finished word |
| out_word | output | 32 | Assembled word |

## Verification
The embedded assertions watch several rules on every cycle. A word strobe must follow an accepted unit. An RGB unit must produce a word on the next cycle. The top byte must stay zero for low-padded RGB. The lane counter must return to zero after a flush. The output word must hold steady between strobes. Two back-to-back byte-mode words without padding are not allowed. Only the bench scenarios can show the exact lane order of every mode, the combined effect of half swapping with each mode, the zero-filled flush at end of line, and the loss of partial data at reset, because these depend on the values fed in.

// File: rtl/pw_pkg.sv
// Shared constants and types for the pixel-to-word packer.
// Assumes a word made of a whole number of byte lanes, at least three lanes wide.
package pw_pkg;
    localparam int PW_LANE_W    = 8;
    localparam int PW_WORD_LANES = 4;
    localparam int PW_WORD_W    = PW_LANE_W * PW_WORD_LANES;
    localparam int PW_HALF_W    = PW_WORD_W / 2;
    localparam int PW_RGB_W     = PW_WORD_W - PW_LANE_W;
    localparam int PW_CNT_W     = $clog2(PW_WORD_LANES);

    typedef enum logic [1:0] {
        PW_BYTE     = 2'd0,
        PW_HALF     = 2'd1,
        PW_RGB      = 2'd2,
        PW_BYTE_ALT = 2'd3
    } pw_mode_e;

    // Number of units that make up one output word in a given mode.
    function automatic logic [PW_CNT_W:0] units_per_word(input pw_mode_e m);
        case (m)
            PW_HALF: return (PW_CNT_W+1)'(2);
            PW_RGB:  return (PW_CNT_W+1)'(1);
            default: return (PW_CNT_W+1)'(PW_WORD_LANES);
        endcase
    endfunction
endpackage

// File: rtl/pw_lane_place.sv
// Places one input unit into its lane of an otherwise zero word.
// Assumes slot counts units already placed in the current word.
module pw_lane_place
    import pw_pkg::*;
(
    input  pw_mode_e               mode,
    input  logic                   msb_first,
    input  logic                   pad_high,
    input  logic [PW_CNT_W-1:0]    slot,
    input  logic [PW_RGB_W-1:0]    data,
    output logic [PW_WORD_W-1:0]   placed
);
    logic                hslot;
    logic [PW_CNT_W-1:0] bslot;

    // Mirror the slot index when the first unit goes to the top lane.
    always_comb begin
        hslot = msb_first ? ~slot[0] : slot[0];
        bslot = msb_first ? (PW_CNT_W'(PW_WORD_LANES - 1) - slot) : slot;
    end

    // Shift the unit into its lane, or pad an RGB pixel to a full word.
    always_comb begin
        case (mode)
            PW_HALF: placed = PW_WORD_W'(data[PW_HALF_W-1:0]) << (hslot ? PW_HALF_W : 0);
            PW_RGB:  placed = pad_high ? {data, PW_LANE_W'(0)} : {PW_LANE_W'(0), data};
            default: placed = PW_WORD_W'(data[PW_LANE_W-1:0]) << (32'(bslot) * PW_LANE_W);
        endcase
    end
endmodule

// File: rtl/pw_accum.sv
// Collects placed units into a word and signals when the word is complete.
// Assumes configuration is stable while a word is partly filled.
module pw_accum
    import pw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  pw_mode_e             mode,
    input  logic                 msb_first,
    input  logic                 pad_high,
    input  logic                 zero_pad,
    input  logic                 in_valid,
    input  logic [PW_RGB_W-1:0]  in_data,
    input  logic                 in_eol,
    output logic [PW_WORD_W-1:0] word,
    output logic                 fire
);
    logic [PW_CNT_W-1:0]  slot_q;
    logic [PW_WORD_W-1:0] acc_q;
    logic [PW_WORD_W-1:0] placed;
    logic                 last_slot;
    logic                 is_byte;

    pw_lane_place i_place (
        .mode      (mode),
        .msb_first (msb_first),
        .pad_high  (pad_high),
        .slot      (slot_q),
        .data      (in_data),
        .placed    (placed)
    );

    // Decide whether the incoming unit completes or flushes the word.
    always_comb begin
        last_slot = ({1'b0, slot_q} + 1'b1) >= units_per_word(mode);
        is_byte   = (mode == PW_BYTE) || (mode == PW_BYTE_ALT);
        fire      = in_valid && (last_slot || (zero_pad && in_eol));
        word      = acc_q | placed;
    end

    // Hold the partial word; clear it whenever a word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            acc_q  <= '0;
        end else if (in_valid) begin
            if (fire) begin
                slot_q <= '0;
                acc_q  <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
                acc_q  <= word;
            end
        end
    end

    p_slot_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (slot_q == '0));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(slot_q) && $stable(acc_q)));
    p_byte_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_byte && !zero_pad) |=> !(fire && is_byte && !zero_pad));
endmodule

// File: rtl/pw_out_stage.sv
// Applies the optional halfword exchange and registers the output word.
// Assumes fire marks a complete word from the accumulator.
module pw_out_stage
    import pw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 swap16,
    input  logic                 fire,
    input  logic [PW_WORD_W-1:0] word,
    output logic                 out_valid,
    output logic [PW_WORD_W-1:0] out_word
);
    logic [PW_WORD_W-1:0] swapped;

    // Route each half straight through or from the opposite half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign swapped[h*PW_HALF_W +: PW_HALF_W] =
            swap16 ? word[(1-h)*PW_HALF_W +: PW_HALF_W] : word[h*PW_HALF_W +: PW_HALF_W];
    end

    // Register the strobe every cycle and the word only when one leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_word <= swapped;
        end
    end

    p_hold_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));
endmodule

// File: rtl/pix_word_packer.sv
// Top level: packs bytes, halfwords or RGB pixels into 32-bit words.
// Assumes no back-pressure at the output and stable configuration mid-word.
module pix_word_packer
    import pw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_msb_first,
    input  logic                 cfg_swap16,
    input  logic                 cfg_pad_high,
    input  logic                 cfg_zero_pad,
    input  logic                 in_valid,
    input  logic [PW_RGB_W-1:0]  in_data,
    input  logic                 in_eol,
    output logic                 out_valid,
    output logic [PW_WORD_W-1:0] out_word
);
    logic [PW_WORD_W-1:0] word;
    logic                 fire;

    pw_accum i_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (pw_mode_e'(cfg_mode)),
        .msb_first (cfg_msb_first),
        .pad_high  (cfg_pad_high),
        .zero_pad  (cfg_zero_pad),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_eol    (in_eol),
        .word      (word),
        .fire      (fire)
    );

    pw_out_stage i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap16    (cfg_swap16),
        .fire      (fire),
        .word      (word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    p_strobe_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    p_rgb_each_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_mode == PW_RGB) |=> out_valid);
    p_rgb_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_mode == PW_RGB && !cfg_pad_high && !cfg_swap16)
        |=> (out_word[PW_WORD_W-1 -: PW_LANE_W] == '0));
endmodule

// File: tb/test_pix_word_packer.sv
`timescale 1ns/1ps
module test_pix_word_packer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic        cfg_msb_first, cfg_swap16, cfg_pad_high, cfg_zero_pad;
    logic        in_valid, in_eol;
    logic [23:0] in_data;
    logic        out_valid;
    logic [31:0] out_word;
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pix_word_packer i_pix_word_packer (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_msb_first(cfg_msb_first),
        .cfg_swap16(cfg_swap16), .cfg_pad_high(cfg_pad_high), .cfg_zero_pad(cfg_zero_pad),
        .in_valid(in_valid), .in_data(in_data), .in_eol(in_eol),
        .out_valid(out_valid), .out_word(out_word)
    );

    typedef struct packed {
        logic [1:0]       mode;
        logic             msb;
        logic             swp;
        logic             padh;
        logic             zp;
        logic [2:0]       n;
        logic [3:0][23:0] u;   // u[0] is sent first
        logic [31:0]      want;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, {24'hFFEE44, 24'h5A5A33, 24'h000122, 24'hABCD11}, 32'h44332211},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, {24'h000044, 24'h000033, 24'h000022, 24'h000011}, 32'h11223344},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, {24'h0, 24'h0, 24'h00BBBB, 24'h77AAAA}, 32'hBBBBAAAA},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, {24'h0, 24'h0, 24'h00BBBB, 24'h00AAAA}, 32'hAAAABBBB},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, {24'h000044, 24'h000033, 24'h000022, 24'h000011}, 32'h22114433},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, {24'h0, 24'h0, 24'h0, 24'hABCDEF}, 32'h00ABCDEF},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, {24'h0, 24'h0, 24'h0, 24'hABCDEF}, 32'hABCDEF00},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, {24'h0, 24'h000033, 24'h000022, 24'h000011}, 32'h00332211},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, {24'h0, 24'h0, 24'h0, 24'h00005A}, 32'h5A000000},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, {24'h0, 24'h0, 24'h00BBBB, 24'h00AAAA}, 32'hBBBBAAAA},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, {24'h000004, 24'h000003, 24'h000002, 24'h000001}, 32'h04030201},
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, {24'h0, 24'h0, 24'h0, 24'h123456}, 32'h34560012},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, {24'h0, 24'h0, 24'h0, 24'h001234}, 32'h00001234}
    };
    localparam string TAGS [NV] = '{"R2", "R3", "R4", "R4", "R5", "R6", "R6",
                                    "R8", "R8", "R5", "R11", "R5", "R8"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Drive one unit at a falling edge and return at the next falling edge.
    task automatic put(input logic [23:0] d, input logic e);
        in_valid = 1'b1; in_data = d; in_eol = e;
        @(negedge clk);
        in_valid = 1'b0; in_eol = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic msb, input logic swp,
                           input logic ph, input logic zp);
        cfg_mode = m; cfg_msb_first = msb; cfg_swap16 = swp; cfg_pad_high = ph; cfg_zero_pad = zp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0; in_data = '0;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 word", out_word, 32'h0);
        rst_n = 1'b1;
        idle(1);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].mode, VECS[v].msb, VECS[v].swp, VECS[v].padh, VECS[v].zp);
            idle(1);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                put(VECS[v].u[k], (k == int'(VECS[v].n) - 1) && VECS[v].zp);
                if (k < int'(VECS[v].n) - 1) check({TAGS[v], " early strobe"}, 32'(out_valid), 32'd0);
            end
            check({TAGS[v], " strobe"}, 32'(out_valid), 32'd1);
            check(TAGS[v], out_word, VECS[v].want);
            idle(2);
        end

        // R7, R12: gaps between units, single-cycle strobe, word held
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        put(24'hA1, 1'b0); put(24'hB2, 1'b0);
        idle(3);
        check("R7 gap no strobe", 32'(out_valid), 32'd0);
        put(24'hC3, 1'b0); idle(1); put(24'hD4, 1'b0);
        check("R7 strobe", 32'(out_valid), 32'd1);
        check("R7 word", out_word, 32'hD4C3B2A1);
        idle(1);
        check("R7 one cycle", 32'(out_valid), 32'd0);
        check("R12 word held", out_word, 32'hD4C3B2A1);
        idle(1);

        // R9: end of line has no effect without zero padding
        put(24'h01, 1'b0); put(24'h02, 1'b1);
        idle(1);
        check("R9 no flush", 32'(out_valid), 32'd0);
        put(24'h03, 1'b0); put(24'h04, 1'b0);
        check("R9 strobe", 32'(out_valid), 32'd1);
        check("R9 word", out_word, 32'h04030201);
        idle(2);

        // R10: end of line without a unit is ignored even with zero padding
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        put(24'h11, 1'b0); put(24'h22, 1'b0);
        in_eol = 1'b1; @(negedge clk); in_eol = 1'b0;
        idle(1);
        check("R10 no flush", 32'(out_valid), 32'd0);
        put(24'h33, 1'b0); put(24'h44, 1'b0);
        check("R10 strobe", 32'(out_valid), 32'd1);
        check("R10 word", out_word, 32'h44332211);
        idle(2);

        // R1: partial word lost at reset
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        put(24'h11, 1'b0); put(24'h22, 1'b0);
        rst_n = 1'b0; idle(2);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset word", out_word, 32'h0);
        rst_n = 1'b1; idle(1);
        put(24'h55, 1'b0); put(24'h66, 1'b0); put(24'h77, 1'b0); put(24'h88, 1'b0);
        check("R1 fresh strobe", 32'(out_valid), 32'd1);
        check("R1 fresh word", out_word, 32'h88776655);
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule